// File: doc/BRIEF.md
# Stack-capable load/store address unit

This unit turns one memory instruction per cycle into an access on a simple synchronous data memory and into register write-backs. It accepts six operations: word load, byte load, word store, byte store, and the two stack operations push and pop. Each request carries a base register value with its register index, a 16-bit signed offset, the data register value with its index, and an operation code. The unit forms the effective address, drives the memory port in the same cycle, and one cycle later presents the loaded value and, for stack operations, the updated base value to the register file.

Push lowers the base by the offset and stores at the lowered address. Pop reads at the base as it stands and then raises the base by the offset. Both write the base register back. Word accesses must be aligned to four bytes; a misaligned word request makes no memory access, writes no register and raises an error flag instead. Byte loads return the selected byte zero-extended, and byte stores enable a single byte lane.

The memory answers a read on the clock edge that follows the request, so the unit keeps a one-stage record of each request to know what to do with the read data. The reset input is asynchronous, active low, and is released on the clock inside the unit, two edges after the pin rises.

Top module: `ldst_stack_unit`

## Requirements
- R1: Operation codes on `req_op` are 0 word load, 1 byte load, 2 word store, 3 byte store, 4 pop, 5 push; a word load reads the byte address base plus offset and presents the full word on `rd_val` with `rd_we` high in the cycle after the request.
- R2: A byte load selects byte lane `addr[1:0]` (lane 0 is bits 7:0) of the read word and returns it zero-extended to 32 bits.
- R3: A word store drives `mem_we` with `mem_be` = 4'b1111 and `mem_wdata` equal to the data register.
- R4: A byte store drives a one-hot `mem_be` with bit `addr[1:0]` set and the low data byte copied onto all four lanes of `mem_wdata`.
- R5: The 16-bit offset is sign-extended before it is added to or subtracted from the base; `mem_addr` carries the effective address with its two low bits cleared.
- R6: Pop reads at the unmodified base and, in the cycle after the request, writes base plus offset to the base register (`base_we`, `base_idx`, `base_val`) and the loaded word to the data register.
- R7: Push stores the data register at base minus offset and, in the cycle after the request, writes base minus offset to the base register; it writes no data register.
- R8: A word load, word store, pop or push whose address has nonzero low two bits makes no memory access, writes no register, and pulses `align_err` for the one cycle after the request.
- R9: A pop whose data and base register indices are equal writes only the loaded word to that register; `base_we` stays low.
- R10: Requests may be issued on consecutive cycles; every response appears exactly one cycle after its request, with no stall.
- R11: While reset is asserted, and for two clock edges after its release, all memory and write-back outputs are low.
- R12: Operation codes 6 and 7 make no memory access, no write-back and no alignment error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed offset |
| req_data | input | 32 | Data register value (stores, push) |
| req_dst | input | 5 | Data register index |
| req_bidx | input | 5 | Base register index |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| rd_we | output | 1 | Data register write enable |
| rd_idx | output | 5 | Data register index |
| rd_val | output | 32 | Loaded value |
| base_we | output | 1 | Base register write enable |
| base_idx | output | 5 | Base register index |
| base_val | output | 32 | Updated base value |
| align_err | output | 1 | Misaligned word access flag |

## Verification
The hardest situation to reach is a pop whose destination and base name the same register while a store to the same word follows on the next cycle, because the response, the read data and the next request all overlap in one cycle. The bench reaches it with explicit back-to-back sequences (push then pop of the same slot, pop with equal indices, store right after a load of the same word) and then with a long run of unbroken requests whose operations, offsets and alignment are varied arithmetically, so that every operation follows every other. Negative offsets and misaligned push and pop are placed directly.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    OP_LDW  = 3'd0,
    OP_LDB  = 3'd1,
    OP_STW  = 3'd2,
    OP_STB  = 3'd3,
    OP_POP  = 3'd4,
    OP_PSH  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } ldst_op_e;

endpackage

// File: rtl/ldst_agen.sv
// Effective address, base update and access classification.
module ldst_agen
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] nbase_o,
  output logic          legal_o,
  output logic          is_ld_o,
  output logic          is_st_o,
  output logic          is_byte_o,
  output logic          upd_base_o,
  output logic          misal_o
);
  localparam int NL = DW / 8;
  localparam int LB = $clog2(NL);

  ldst_op_e      op;
  logic [DW-1:0] off_x;
  logic [DW-1:0] sum;
  logic [DW-1:0] dif;

  assign op    = ldst_op_e'(op_i);
  assign off_x = {{(DW-OW){off_i[OW-1]}}, off_i};
  assign sum   = base_i + off_x;
  assign dif   = base_i - off_x;

  always_comb begin
    addr_o     = sum;
    nbase_o    = base_i;
    legal_o    = 1'b1;
    is_ld_o    = 1'b0;
    is_st_o    = 1'b0;
    is_byte_o  = 1'b0;
    upd_base_o = 1'b0;
    case (op)
      OP_LDW: is_ld_o = 1'b1;
      OP_LDB: begin
        is_ld_o   = 1'b1;
        is_byte_o = 1'b1;
      end
      OP_STW: is_st_o = 1'b1;
      OP_STB: begin
        is_st_o   = 1'b1;
        is_byte_o = 1'b1;
      end
      OP_POP: begin
        addr_o     = base_i;
        nbase_o    = sum;
        is_ld_o    = 1'b1;
        upd_base_o = 1'b1;
      end
      OP_PSH: begin
        addr_o     = dif;
        nbase_o    = dif;
        is_st_o    = 1'b1;
        upd_base_o = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
  end

  assign misal_o = legal_o && !is_byte_o && (addr_o[LB-1:0] != '0);

endmodule

// File: rtl/ldst_lane.sv
// Byte-lane steering for stores and byte selection for loads.
module ldst_lane #(
  parameter int DW = 32
) (
  input  logic                     st_byte_i,
  input  logic [$clog2(DW/8)-1:0]  st_lane_i,
  input  logic [DW-1:0]            st_data_i,
  output logic [DW/8-1:0]          st_be_o,
  output logic [DW-1:0]            st_wdata_o,
  input  logic                     ld_byte_i,
  input  logic [$clog2(DW/8)-1:0]  ld_lane_i,
  input  logic [DW-1:0]            ld_rdata_i,
  output logic [DW-1:0]            ld_val_o
);
  localparam int NL = DW / 8;
  localparam int LB = $clog2(NL);

  logic [7:0] ld_sel;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign st_wdata_o[g*8 +: 8] = st_byte_i ? st_data_i[7:0] : st_data_i[g*8 +: 8];
    assign st_be_o[g]           = !st_byte_i || (st_lane_i == LB'(g));
  end

  always_comb begin
    ld_sel = '0;
    for (int i = 0; i < NL; i++) begin
      if (ld_lane_i == LB'(i)) ld_sel = ld_rdata_i[i*8 +: 8];
    end
  end

  assign ld_val_o = ld_byte_i ? {{(DW-8){1'b0}}, ld_sel} : ld_rdata_i;

endmodule

// File: rtl/ldst_resp.sv
// One-stage record of the issued request, used when read data returns.
module ldst_resp #(
  parameter int DW = 32,
  parameter int RW = 5,
  parameter int LB = 2
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          iss_ld_i,
  input  logic          iss_byte_i,
  input  logic [LB-1:0] iss_lane_i,
  input  logic [RW-1:0] iss_dst_i,
  input  logic          iss_bwe_i,
  input  logic [RW-1:0] iss_bidx_i,
  input  logic [DW-1:0] iss_bval_i,
  input  logic          iss_err_i,
  output logic          ld_q_o,
  output logic          byte_q_o,
  output logic [LB-1:0] lane_q_o,
  output logic [RW-1:0] dst_q_o,
  output logic          bwe_q_o,
  output logic [RW-1:0] bidx_q_o,
  output logic [DW-1:0] bval_q_o,
  output logic          err_q_o
);
  logic          ld_d, bwe_d, err_d, byte_d;
  logic [LB-1:0] lane_d;
  logic [RW-1:0] dst_d, bidx_d;
  logic [DW-1:0] bval_d;
  logic          ld_en, b_en;

  assign ld_en = iss_ld_i;
  assign b_en  = iss_bwe_i;

  always_comb begin
    ld_d   = iss_ld_i;
    bwe_d  = iss_bwe_i;
    err_d  = iss_err_i;
    byte_d = byte_q_o;
    lane_d = lane_q_o;
    dst_d  = dst_q_o;
    bidx_d = bidx_q_o;
    bval_d = bval_q_o;
    if (ld_en) begin
      byte_d = iss_byte_i;
      lane_d = iss_lane_i;
      dst_d  = iss_dst_i;
    end
    if (b_en) begin
      bidx_d = iss_bidx_i;
      bval_d = iss_bval_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ld_q_o   <= 1'b0;
      bwe_q_o  <= 1'b0;
      err_q_o  <= 1'b0;
      byte_q_o <= 1'b0;
      lane_q_o <= '0;
      dst_q_o  <= '0;
      bidx_q_o <= '0;
      bval_q_o <= '0;
    end else begin
      ld_q_o   <= ld_d;
      bwe_q_o  <= bwe_d;
      err_q_o  <= err_d;
      byte_q_o <= byte_d;
      lane_q_o <= lane_d;
      dst_q_o  <= dst_d;
      bidx_q_o <= bidx_d;
      bval_q_o <= bval_d;
    end
  end

endmodule

// File: rtl/ldst_stack_unit.sv
module ldst_stack_unit #(
  parameter int DW = 32,
  parameter int OW = 16,
  parameter int RW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [DW-1:0]     req_base,
  input  logic [OW-1:0]     req_off,
  input  logic [DW-1:0]     req_data,
  input  logic [RW-1:0]     req_dst,
  input  logic [RW-1:0]     req_bidx,
  output logic              mem_en,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW/8-1:0]   mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rd_we,
  output logic [RW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_val,
  output logic              base_we,
  output logic [RW-1:0]     base_idx,
  output logic [DW-1:0]     base_val,
  output logic              align_err
);
  localparam int NL = DW / 8;
  localparam int LB = $clog2(NL);

  // reset release synchroniser
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [DW-1:0] addr, nbase;
  logic          legal, is_ld, is_st, is_byte, upd_base, misal;
  logic          live, go;

  ldst_agen #(.DW(DW), .OW(OW)) u_agen (
    .op_i       (req_op),
    .base_i     (req_base),
    .off_i      (req_off),
    .addr_o     (addr),
    .nbase_o    (nbase),
    .legal_o    (legal),
    .is_ld_o    (is_ld),
    .is_st_o    (is_st),
    .is_byte_o  (is_byte),
    .upd_base_o (upd_base),
    .misal_o    (misal)
  );

  assign live = req_valid && srst_n && legal;
  assign go   = live && !misal;

  logic          ld_q, byte_q, bwe_q, err_q;
  logic [LB-1:0] lane_q;
  logic [RW-1:0] dst_q, bidx_q;
  logic [DW-1:0] bval_q;
  logic [NL-1:0] be_raw;

  ldst_lane #(.DW(DW)) u_lane (
    .st_byte_i  (is_byte),
    .st_lane_i  (addr[LB-1:0]),
    .st_data_i  (req_data),
    .st_be_o    (be_raw),
    .st_wdata_o (mem_wdata),
    .ld_byte_i  (byte_q),
    .ld_lane_i  (lane_q),
    .ld_rdata_i (mem_rdata),
    .ld_val_o   (rd_val)
  );

  assign mem_en   = go && (is_ld || is_st);
  assign mem_we   = go && is_st;
  assign mem_addr = {addr[DW-1:LB], {LB{1'b0}}};
  assign mem_be   = mem_we ? be_raw : '0;

  logic iss_bwe;
  // a pop naming one register for both roles keeps only the loaded word
  assign iss_bwe = go && upd_base && !(is_ld && (req_dst == req_bidx));

  ldst_resp #(.DW(DW), .RW(RW), .LB(LB)) u_resp (
    .clk        (clk),
    .srst_n     (srst_n),
    .iss_ld_i   (go && is_ld),
    .iss_byte_i (is_byte),
    .iss_lane_i (addr[LB-1:0]),
    .iss_dst_i  (req_dst),
    .iss_bwe_i  (iss_bwe),
    .iss_bidx_i (req_bidx),
    .iss_bval_i (nbase),
    .iss_err_i  (live && misal),
    .ld_q_o     (ld_q),
    .byte_q_o   (byte_q),
    .lane_q_o   (lane_q),
    .dst_q_o    (dst_q),
    .bwe_q_o    (bwe_q),
    .bidx_q_o   (bidx_q),
    .bval_q_o   (bval_q),
    .err_q_o    (err_q)
  );

  assign rd_we     = ld_q;
  assign rd_idx    = dst_q;
  assign base_we   = bwe_q;
  assign base_idx  = bidx_q;
  assign base_val  = bval_q;
  assign align_err = err_q;

endmodule

// File: rtl/ldst_chk.sv
module ldst_chk #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            mem_en,
  input logic            mem_we,
  input logic [DW/8-1:0] mem_be,
  input logic            rd_we,
  input logic [RW-1:0]   rd_idx,
  input logic            base_we,
  input logic [RW-1:0]   base_idx,
  input logic            align_err
);
  // R10
  ld_resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> $past(mem_en && !mem_we));

  // R9
  pop_same_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && base_we) |-> (rd_idx != base_idx));

  // R8
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!rd_we && !base_we));

  // R4
  store_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (($countones(mem_be) == 1) || (mem_be == '1)));

  // R6
  base_wb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> $past(req_valid));

  // R3
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

endmodule

bind ldst_stack_unit ldst_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .rd_we     (rd_we),
  .rd_idx    (rd_idx),
  .base_we   (base_we),
  .base_idx  (base_idx),
  .align_err (align_err)
);

// File: tb/tb_ldst_stack_unit.sv
`timescale 1ns/1ps
module tb_ldst_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_base, req_data;
  logic [15:0] req_off;
  logic [4:0]  req_dst, req_bidx;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic [3:0]  mem_be;
  logic        rd_we, base_we, align_err;
  logic [4:0]  rd_idx, base_idx;
  logic [31:0] rd_val, base_val;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ldst_stack_unit dut (.*);

  // behavioural synchronous memory, 256 words
  logic [31:0] bmem [256];
  logic [31:0] refm [256];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) bmem[mem_addr[9:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
      end else begin
        mem_rdata <= bmem[mem_addr[9:2]];
      end
    end
  end

  // expected response for the request issued one cycle earlier
  logic        e_rd_we = 0, e_bwe = 0, e_err = 0;
  logic [4:0]  e_rd_idx = 0, e_bidx = 0;
  logic [31:0] e_rd_val = 0, e_bval = 0;
  string       e_tag = "R10";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_resp();
    chk(rd_we === e_rd_we, e_tag, "rd_we", 32'(rd_we), 32'(e_rd_we));
    if (e_rd_we) begin
      chk(rd_idx === e_rd_idx, e_tag, "rd_idx", 32'(rd_idx), 32'(e_rd_idx));
      chk(rd_val === e_rd_val, e_tag, "rd_val", rd_val, e_rd_val);
    end
    chk(base_we === e_bwe, e_tag, "base_we", 32'(base_we), 32'(e_bwe));
    if (e_bwe) begin
      chk(base_idx === e_bidx, e_tag, "base_idx", 32'(base_idx), 32'(e_bidx));
      chk(base_val === e_bval, e_tag, "base_val", base_val, e_bval);
    end
    chk(align_err === e_err, e_tag, "align_err", 32'(align_err), 32'(e_err));
  endtask

  // one request (or idle when v=0); checks previous response and this request's port activity
  task automatic step(input bit v, input int op, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] data,
                      input int dst, input int bidx, input string tag);
    logic [31:0] sx, ad, nb, rw;
    bit word, legal, mis, go, ld, st, upd;
    @(negedge clk);
    req_valid = v;
    req_op    = 3'(op);
    req_base  = base;
    req_off   = off;
    req_data  = data;
    req_dst   = 5'(dst);
    req_bidx  = 5'(bidx);
    #2;
    check_resp();
    sx    = {{16{off[15]}}, off};
    ad    = (op == 5) ? base - sx : (op == 4) ? base : base + sx;
    nb    = (op == 5) ? base - sx : base + sx;
    legal = (op < 6);
    word  = (op == 0) || (op == 2) || (op == 4) || (op == 5);
    mis   = word && (ad[1:0] != 2'b00);
    go    = v && legal && !mis;
    ld    = (op == 0) || (op == 1) || (op == 4);
    st    = (op == 2) || (op == 3) || (op == 5);
    upd   = (op == 4) || (op == 5);
    chk(mem_en === (go && (ld || st)), tag, "mem_en", 32'(mem_en), 32'(go && (ld || st)));
    chk(mem_we === (go && st), tag, "mem_we", 32'(mem_we), 32'(go && st));
    if (go && (ld || st))
      chk(mem_addr === {ad[31:2], 2'b00}, tag, "mem_addr", mem_addr, {ad[31:2], 2'b00});
    if (go && st) begin
      if (word) begin
        chk(mem_be === 4'hF, tag, "mem_be", 32'(mem_be), 32'hF);
        chk(mem_wdata === data, tag, "mem_wdata", mem_wdata, data);
      end else begin
        chk(mem_be === 4'(1 << ad[1:0]), tag, "mem_be", 32'(mem_be), 32'(1 << ad[1:0]));
        chk(mem_wdata === {4{data[7:0]}}, tag, "mem_wdata", mem_wdata, {4{data[7:0]}});
      end
    end
    rw       = refm[ad[9:2]];
    e_rd_we  = go && ld;
    e_rd_idx = 5'(dst);
    e_rd_val = (op == 1) ? {24'h0, rw[ad[1:0]*8 +: 8]} : rw;
    e_bwe    = go && upd && !((op == 4) && (dst == bidx));
    e_bidx   = 5'(bidx);
    e_bval   = nb;
    e_err    = v && legal && mis;
    e_tag    = tag;
    if (go && st) begin
      if (word) refm[ad[9:2]] = data;
      else      refm[ad[9:2]][ad[1:0]*8 +: 8] = data[7:0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = (32'(i) * 32'h01030507) ^ 32'hA55A0F00;
      refm[i] = bmem[i];
    end
    mem_rdata = '0;
    rst_n = 1'b0;
    req_valid = 0; req_op = 0; req_base = 0; req_off = 0;
    req_data = 0; req_dst = 0; req_bidx = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({mem_en, mem_we, rd_we, base_we, align_err} === 5'b0, "R11", "outputs in reset",
        32'({mem_en, mem_we, rd_we, base_we, align_err}), 32'h0);
    chk(mem_be === 4'h0, "R11", "mem_be in reset", 32'(mem_be), 32'h0);
    rst_n = 1'b1;
    // R11: a request during the release window is ignored
    @(negedge clk);
    req_valid = 1; req_op = 3'd2; req_base = 32'h10; req_off = 0; req_data = 32'h1;
    #2;
    chk(mem_en === 1'b0, "R11", "mem_en during release", 32'(mem_en), 32'h0);
    req_valid = 0;
    repeat (3) @(negedge clk);

    step(1, 0, 32'h40, 16'd4, 0, 1, 2, "R1");
    step(1, 1, 32'h80, 16'd0, 0, 3, 2, "R2");
    step(1, 1, 32'h80, 16'd1, 0, 4, 2, "R2");
    step(1, 1, 32'h80, 16'd2, 0, 5, 2, "R2");
    step(1, 1, 32'h80, 16'd3, 0, 6, 2, "R2");
    step(1, 2, 32'h100, 16'd8, 32'hDEADBEEF, 0, 2, "R3");
    step(1, 0, 32'h108, 16'd0, 0, 8, 2, "R3");
    step(1, 3, 32'h104, 16'd1, 32'h1234565A, 0, 2, "R4");
    step(1, 3, 32'h104, 16'd2, 32'h000000C3, 0, 2, "R4");
    step(1, 0, 32'h104, 16'd0, 0, 9, 2, "R4");
    step(1, 0, 32'h200, 16'hFFF8, 0, 10, 2, "R5");
    step(1, 2, 32'h210, 16'hFFF0, 32'h0BADF00D, 0, 2, "R5");
    step(1, 5, 32'h300, 16'd4, 32'h11223344, 0, 29, "R7");
    step(1, 4, 32'h2FC, 16'd4, 0, 3, 29, "R6");
    step(1, 5, 32'h300, 16'hFFF8, 32'h55667788, 0, 28, "R7");
    step(1, 4, 32'h308, 16'hFFF8, 0, 11, 28, "R6");
    step(1, 4, 32'h300, 16'd4, 0, 7, 7, "R9");
    step(1, 0, 32'h102, 16'd0, 0, 12, 2, "R8");
    step(1, 5, 32'h300, 16'd2, 32'h99, 0, 29, "R8");
    step(1, 4, 32'h301, 16'd4, 0, 13, 29, "R8");
    step(1, 2, 32'h100, 16'd3, 32'h77, 0, 2, "R8");
    step(1, 3, 32'h101, 16'd2, 32'hEE, 0, 2, "R4");
    step(1, 6, 32'h100, 16'd0, 32'h44, 14, 15, "R12");
    step(1, 7, 32'h101, 16'd0, 32'h44, 14, 15, "R12");
    step(1, 0, 32'h100, 16'd0, 0, 16, 2, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R10");

    // R10: unbroken stream of mixed requests
    for (int i = 0; i < 400; i++) begin
      int op, b, o, d, x;
      op = (i * 7 + i / 5) % 8;
      b  = 32'h180 + ((i * 44) % 256) + ((i % 9 == 0) ? 2 : 0);
      o  = ((i * 13) % 48) - 24;
      d  = i * 32'h01020304 + 32'h5A;
      x  = (i * 3) % 32;
      step(1, op, 32'(b), 16'(o), 32'(d), x, (i % 11 == 0) ? x : (x + 1) % 32, "R10");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule